// File: doc/BRIEF.md
# Line BIP-8 Error Monitor

This block checks line-level parity on a descrambled, byte-serial stream that carries `NCH` interleaved STS-1 signals. Every byte arrives with markers: a valid flag, a frame-start flag, a flag for section overhead bytes, a flag for the position of the parity byte, and the index of the channel the byte belongs to. For each channel the block folds every non-section-overhead byte of a frame into an 8-bit even parity. In the next frame it compares that value with the parity byte it receives for the same channel.

Mismatches are counted on two time scales. Per-frame totals of bit and block errors appear for one cycle after each frame boundary, together with a strobe. Saturating one-second totals are copied into readable caches on each one-second pulse. Any mismatch also sets a sticky status bit, which can raise a maskable interrupt. Counting stops while any line defect input is active. After a defect clears, or after reset, a full frame must pass before any comparison is made again.

Top module: `line_parity_mon`

## Requirements
- R1: The parity of channel c over frame k is the XOR of all valid bytes of c in frame k whose section-overhead flag is low. The parity byte itself is one of these bytes. When the channel's parity byte in frame k+1 equals this value, no error is counted, whatever the section overhead bytes contain.
- R2: A parity byte is compared only when a complete frame has started since reset, and since the last cycle in which a defect input was high. Parity bytes in the first frame after either event produce no error.
- R3: For each compared parity byte, the bit error count grows by the number of set bits in (received XOR expected). The block error count grows by one when that value is nonzero.
- R4: A valid byte with frame_start high ends the previous frame. In the next cycle frm_en is high for one cycle, and frm_bits/frm_blks carry that frame's totals. In every other cycle both counts read 0.
- R5: When sec_pulse is high, the running one-second totals are copied into the caches, visible from the next cycle at address 0 (bits) and address 1 (blocks). The running totals then restart from the errors of the pulse cycle itself, so no error is lost.
- R6: The one-second totals saturate at all ones (SB_W and SK_W bits) instead of wrapping.
- R7: With cfg_cnt_clr_rd=1, a read of address 0 or 1 clears that cache, unless a transfer happens in the same cycle. With cfg_cnt_clr_rd=0, reads leave the caches unchanged.
- R8: Status (address 2, bit 0) is set by any block error. With cfg_sts_clr_rd=1 a read of address 2 clears it. With cfg_sts_clr_rd=0 reads leave it set and a write with reg_wdata=1 clears it. A new error in the same cycle wins over the clear.
- R9: irq is high when the status is 1 and the mask (address 3, bit 0, written by reg_wr) is 0. The mask resets to 1.
- R10: While any of def_sef, def_los, def_lof or def_ais is high, no parity byte is compared.
- R11: After reset, frm_en, frm_bits, frm_blks, irq, both caches and the status are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Descrambled data byte |
| din_vld | input | 1 | Byte valid |
| frame_start | input | 1 | First byte of a frame |
| soh | input | 1 | Byte is section overhead |
| par_pos | input | 1 | Byte is the channel's parity byte |
| ch_idx | input | CH_W | Channel index of the byte |
| sec_pulse | input | 1 | One-second tick |
| def_sef | input | 1 | Severely errored frame defect |
| def_los | input | 1 | Loss of signal defect |
| def_lof | input | 1 | Loss of frame defect |
| def_ais | input | 1 | Line AIS defect |
| cfg_cnt_clr_rd | input | 1 | Caches clear on read when 1 |
| cfg_sts_clr_rd | input | 1 | Status clears on read when 1, on write when 0 |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 1 | Write data bit |
| reg_rdata | output | RD_W | Read data, combinational from reg_addr |
| frm_en | output | 1 | Per-frame count strobe |
| frm_bits | output | FB_W | Per-frame bit errors |
| frm_blks | output | FK_W | Per-frame block errors |
| irq | output | 1 | Interrupt |

## Verification
The hardest situation to reach is an error that lands in the same cycle as the one-second transfer. The stimulus raises sec_pulse exactly on the byte that carries a corrupted parity byte, then checks that the next period's cache holds those bits. The defect recovery path is also hard to reach. A frame is sent under loss of signal, then a frame with every parity byte corrupted directly after the defect clears, and the bench checks that the corruption shows only once a full clean frame has passed. Saturation is reached by narrowing the one-second counters with parameters and sending frames whose every parity byte is inverted.

// File: rtl/line_par_pkg.sv
package line_par_pkg;
  typedef enum logic [1:0] {
    RA_BITS = 2'd0,
    RA_BLKS = 2'd1,
    RA_STAT = 2'd2,
    RA_MASK = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/lp_parity_bank.sv
module lp_parity_bank #(
  parameter int NCH = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      din,
  input  logic            din_vld,
  input  logic            frame_start,
  input  logic            soh,
  input  logic            par_pos,
  input  logic [CH_W-1:0] ch_idx,
  input  logic            defect,
  output logic [7:0]      err_mask
);
  logic [7:0]     acc_q  [NCH];
  logic [7:0]     acc_d  [NCH];
  logic [7:0]     prev_q [NCH];
  logic [7:0]     prev_d [NCH];
  logic [NCH-1:0] ok_q, ok_d;
  logic           seen_q, seen_d;
  logic           ftick;
  logic [7:0]     sel_prev;
  logic           sel_ok;

  assign ftick = din_vld & frame_start;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [7:0] base;
    logic       hit;
    always_comb begin
      base      = ftick ? 8'h00 : acc_q[c];
      hit       = din_vld & ~soh & (ch_idx == CH_W'(c));
      acc_d[c]  = hit ? (base ^ din) : base;
      prev_d[c] = ftick ? acc_q[c] : prev_q[c];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[c]  <= 8'h00;
        prev_q[c] <= 8'h00;
      end else begin
        acc_q[c]  <= acc_d[c];
        prev_q[c] <= prev_d[c];
      end
    end
  end

  always_comb begin
    if (defect) begin
      ok_d   = '0;
      seen_d = 1'b0;
    end else if (ftick) begin
      ok_d   = {NCH{seen_q}};
      seen_d = 1'b1;
    end else begin
      ok_d   = ok_q;
      seen_d = seen_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= '0;
      seen_q <= 1'b0;
    end else begin
      ok_q   <= ok_d;
      seen_q <= seen_d;
    end
  end

  always_comb begin
    sel_prev = 8'h00;
    sel_ok   = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_idx == CH_W'(c)) begin
        sel_prev = prev_q[c];
        sel_ok   = ok_q[c];
      end
    end
  end

  assign err_mask = (din_vld & par_pos & sel_ok & ~defect) ? (din ^ sel_prev) : 8'h00;

  // R10 / R2: a defect cycle leaves no channel armed for comparison
  p_defect_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(defect) |-> (ok_q == '0 && !seen_q));
endmodule

// File: rtl/lp_err_count.sv
module lp_err_count #(
  parameter int NCH  = 4,
  parameter int SB_W = 24,
  parameter int SK_W = 21,
  localparam int FB_W = $clog2(8*NCH + 1),
  localparam int FK_W = $clog2(NCH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      err_mask,
  input  logic            frame_tick,
  input  logic            sec_pulse,
  output logic            frm_en,
  output logic [FB_W-1:0] frm_bits,
  output logic [FK_W-1:0] frm_blks,
  output logic [SB_W-1:0] run_bits,
  output logic [SK_W-1:0] run_blks,
  output logic            err_hit
);
  logic [3:0]      nb;
  logic [FB_W-1:0] fb_q, fb_d, fo_b_d;
  logic [FK_W-1:0] fk_q, fk_d, fo_k_d;
  logic            fen_d;
  logic [SB_W-1:0] rb_d;
  logic [SK_W-1:0] rk_d;
  logic [SB_W:0]   sum_b;
  logic [SK_W:0]   sum_k;

  assign nb      = 4'($countones(err_mask));
  assign err_hit = |err_mask;

  always_comb begin
    if (frame_tick) begin
      fo_b_d = fb_q;
      fo_k_d = fk_q;
      fen_d  = 1'b1;
      fb_d   = FB_W'(nb);
      fk_d   = FK_W'(err_hit);
    end else begin
      fo_b_d = '0;
      fo_k_d = '0;
      fen_d  = 1'b0;
      fb_d   = fb_q + FB_W'(nb);
      fk_d   = fk_q + FK_W'(err_hit);
    end
  end

  always_comb begin
    sum_b = {1'b0, run_bits} + (SB_W+1)'(nb);
    sum_k = {1'b0, run_blks} + (SK_W+1)'(err_hit);
    if (sec_pulse) begin
      rb_d = SB_W'(nb);
      rk_d = SK_W'(err_hit);
    end else begin
      rb_d = sum_b[SB_W] ? {SB_W{1'b1}} : sum_b[SB_W-1:0];
      rk_d = sum_k[SK_W] ? {SK_W{1'b1}} : sum_k[SK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q     <= '0;
      fk_q     <= '0;
      frm_en   <= 1'b0;
      frm_bits <= '0;
      frm_blks <= '0;
      run_bits <= '0;
      run_blks <= '0;
    end else begin
      fb_q     <= fb_d;
      fk_q     <= fk_d;
      frm_en   <= fen_d;
      frm_bits <= fo_b_d;
      frm_blks <= fo_k_d;
      run_bits <= rb_d;
      run_blks <= rk_d;
    end
  end

  // R6: a saturated total stays saturated until a transfer restarts it
  p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_bits == {SB_W{1'b1}} && !sec_pulse) |=> (run_bits == {SB_W{1'b1}}));
  // R3: each errored parity byte adds at most eight bit errors
  p_frm_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_en |-> (int'(frm_bits) <= 8 * int'(frm_blks)));
  // R4: counts are only presented alongside the strobe
  p_frm_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_en |-> (frm_bits == '0 && frm_blks == '0));
endmodule

// File: rtl/lp_reg_if.sv
module lp_reg_if
  import line_par_pkg::*;
#(
  parameter int SB_W = 24,
  parameter int SK_W = 21,
  localparam int RD_W = (SB_W > SK_W) ? SB_W : SK_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_en,
  input  logic [SB_W-1:0] xfer_bits,
  input  logic [SK_W-1:0] xfer_blks,
  input  logic            err_hit,
  input  logic            cfg_cnt_clr_rd,
  input  logic            cfg_sts_clr_rd,
  input  logic            reg_rd,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wdata,
  output logic [RD_W-1:0] reg_rdata,
  output logic            irq
);
  reg_addr_e       addr;
  logic [SB_W-1:0] cb_q, cb_d;
  logic [SK_W-1:0] ck_q, ck_d;
  logic            sts_q, sts_d, msk_q, msk_d;
  logic            rd_bits, rd_blks, sts_clr;

  assign addr    = reg_addr_e'(reg_addr);
  assign rd_bits = reg_rd & (addr == RA_BITS);
  assign rd_blks = reg_rd & (addr == RA_BLKS);
  assign sts_clr = (addr == RA_STAT) & (cfg_sts_clr_rd ? reg_rd : (reg_wr & reg_wdata));

  always_comb begin
    if (xfer_en) begin
      cb_d = xfer_bits;
      ck_d = xfer_blks;
    end else begin
      cb_d = (rd_bits & cfg_cnt_clr_rd) ? '0 : cb_q;
      ck_d = (rd_blks & cfg_cnt_clr_rd) ? '0 : ck_q;
    end
    sts_d = err_hit | (sts_q & ~sts_clr);
    msk_d = (reg_wr & (addr == RA_MASK)) ? reg_wdata : msk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cb_q  <= '0;
      ck_q  <= '0;
      sts_q <= 1'b0;
      msk_q <= 1'b1;
    end else begin
      cb_q  <= cb_d;
      ck_q  <= ck_d;
      sts_q <= sts_d;
      msk_q <= msk_d;
    end
  end

  always_comb begin
    unique case (addr)
      RA_BITS: reg_rdata = RD_W'(cb_q);
      RA_BLKS: reg_rdata = RD_W'(ck_q);
      RA_STAT: reg_rdata = RD_W'(sts_q);
      default: reg_rdata = RD_W'(msk_q);
    endcase
  end

  assign irq = sts_q & ~msk_q;

  // R8: the sticky bit only rises because of a detected error
  p_sts_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(err_hit));
  // R7: a clearing read empties the cache when no transfer collides
  p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_bits && cfg_cnt_clr_rd && !xfer_en) |=> (cb_q == '0));
endmodule

// File: rtl/line_parity_mon.sv
module line_parity_mon #(
  parameter int NCH  = 4,
  parameter int SB_W = 24,
  parameter int SK_W = 21,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int FB_W = $clog2(8*NCH + 1),
  localparam int FK_W = $clog2(NCH + 1),
  localparam int RD_W = (SB_W > SK_W) ? SB_W : SK_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      din,
  input  logic            din_vld,
  input  logic            frame_start,
  input  logic            soh,
  input  logic            par_pos,
  input  logic [CH_W-1:0] ch_idx,
  input  logic            sec_pulse,
  input  logic            def_sef,
  input  logic            def_los,
  input  logic            def_lof,
  input  logic            def_ais,
  input  logic            cfg_cnt_clr_rd,
  input  logic            cfg_sts_clr_rd,
  input  logic            reg_rd,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wdata,
  output logic [RD_W-1:0] reg_rdata,
  output logic            frm_en,
  output logic [FB_W-1:0] frm_bits,
  output logic [FK_W-1:0] frm_blks,
  output logic            irq
);
  logic [7:0]      err_mask;
  logic            defect, err_hit;
  logic [SB_W-1:0] run_bits;
  logic [SK_W-1:0] run_blks;

  assign defect = def_sef | def_los | def_lof | def_ais;

  lp_parity_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld),
    .frame_start(frame_start), .soh(soh), .par_pos(par_pos),
    .ch_idx(ch_idx), .defect(defect), .err_mask(err_mask)
  );

  lp_err_count #(.NCH(NCH), .SB_W(SB_W), .SK_W(SK_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .err_mask(err_mask),
    .frame_tick(din_vld & frame_start), .sec_pulse(sec_pulse),
    .frm_en(frm_en), .frm_bits(frm_bits), .frm_blks(frm_blks),
    .run_bits(run_bits), .run_blks(run_blks), .err_hit(err_hit)
  );

  lp_reg_if #(.SB_W(SB_W), .SK_W(SK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .xfer_en(sec_pulse),
    .xfer_bits(run_bits), .xfer_blks(run_blks), .err_hit(err_hit),
    .cfg_cnt_clr_rd(cfg_cnt_clr_rd), .cfg_sts_clr_rd(cfg_sts_clr_rd),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );
endmodule

// File: tb/line_parity_mon_test.sv
module line_parity_mon_test;
  localparam int NCH = 4;
  localparam int SBW = 6;
  localparam int SKW = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] din;
  logic       din_vld, frame_start, soh, par_pos;
  logic [1:0] ch_idx;
  logic       sec_pulse, def_sef, def_los, def_lof, def_ais;
  logic       cfg_cnt_clr_rd, cfg_sts_clr_rd, reg_rd, reg_wr, reg_wdata;
  logic [1:0] reg_addr;
  logic [5:0] reg_rdata;
  logic       frm_en, irq;
  logic [5:0] frm_bits;
  logic [2:0] frm_blks;

  line_parity_mon #(.NCH(NCH), .SB_W(SBW), .SK_W(SKW)) uut (
    .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld),
    .frame_start(frame_start), .soh(soh), .par_pos(par_pos), .ch_idx(ch_idx),
    .sec_pulse(sec_pulse), .def_sef(def_sef), .def_los(def_los),
    .def_lof(def_lof), .def_ais(def_ais), .cfg_cnt_clr_rd(cfg_cnt_clr_rd),
    .cfg_sts_clr_rd(cfg_sts_clr_rd), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frm_en(frm_en), .frm_bits(frm_bits), .frm_blks(frm_blks), .irq(irq)
  );

  always #4 clk = ~clk;

  int compared = 0;
  int mismatched = 0;

  // reference model state
  logic [7:0] m_acc [NCH];
  logic [7:0] m_prev[NCH];
  bit         m_ok  [NCH];
  bit         m_seen, m_fen, m_sts, m_msk;
  int         m_fb, m_fk, m_ofb, m_ofk, m_rb, m_rk, m_cb, m_ck;

  // bench-side parity of what was actually sent
  logic [7:0] cur_par [NCH];
  logic [7:0] sent_par[NCH];
  int last_fb, last_fk, last_rd;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rd_exp();
    case (reg_addr)
      2'd0: return m_cb;
      2'd1: return m_ck;
      2'd2: return int'(m_sts);
      default: return int'(m_msk);
    endcase
  endfunction

  task automatic model_step();
    bit         dfx, ft;
    logic [7:0] em;
    int         nb, bk;
    dfx = def_sef | def_los | def_lof | def_ais;
    ft  = din_vld & frame_start;
    em  = 8'h00;
    if (din_vld && par_pos && m_ok[ch_idx] && !dfx) em = din ^ m_prev[ch_idx];
    nb = $countones(em);
    bk = (em != 0) ? 1 : 0;
    if (ft) begin
      m_fen = 1; m_ofb = m_fb; m_ofk = m_fk; m_fb = nb; m_fk = bk;
    end else begin
      m_fen = 0; m_ofb = 0; m_ofk = 0; m_fb += nb; m_fk += bk;
    end
    if (sec_pulse) begin
      m_cb = m_rb; m_ck = m_rk; m_rb = nb; m_rk = bk;
    end else begin
      if (reg_rd && reg_addr == 2'd0 && cfg_cnt_clr_rd) m_cb = 0;
      if (reg_rd && reg_addr == 2'd1 && cfg_cnt_clr_rd) m_ck = 0;
      m_rb = (m_rb + nb > 63) ? 63 : m_rb + nb;
      m_rk = (m_rk + bk > 15) ? 15 : m_rk + bk;
    end
    if (bk != 0) m_sts = 1;
    else if (reg_addr == 2'd2 && (cfg_sts_clr_rd ? reg_rd : (reg_wr && reg_wdata))) m_sts = 0;
    if (reg_wr && reg_addr == 2'd3) m_msk = reg_wdata;
    if (dfx) begin
      m_seen = 0;
      for (int c = 0; c < NCH; c++) m_ok[c] = 0;
    end else if (ft) begin
      for (int c = 0; c < NCH; c++) m_ok[c] = m_seen;
      m_seen = 1;
    end
    if (ft) for (int c = 0; c < NCH; c++) begin m_prev[c] = m_acc[c]; m_acc[c] = 8'h00; end
    if (din_vld && !soh) m_acc[ch_idx] ^= din;
  endtask

  // inputs are set at the falling edge before this is called
  task automatic cyc();
    #1;
    chk(reg_addr == 2'd2 ? "R8 rdata" : (reg_addr == 2'd3 ? "R9 rdata" : "R5 rdata"),
        int'(reg_rdata), rd_exp());
    last_rd = int'(reg_rdata);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R4 frm_en", int'(frm_en), int'(m_fen));
    chk("R4 frm_bits", int'(frm_bits), m_ofb);
    chk("R4 frm_blks", int'(frm_blks), m_ofk);
    chk("R9 irq", int'(irq), int'(m_sts & ~m_msk));
    if (frm_en) begin last_fb = int'(frm_bits); last_fk = int'(frm_blks); end
  endtask

  task automatic idle_in();
    din = $urandom; din_vld = 0; frame_start = 0; soh = 0; par_pos = 1;
    ch_idx = 2'($urandom); sec_pulse = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic idle(input bit pulse);
    idle_in(); sec_pulse = pulse; cyc();
  endtask

  task automatic rd(input int a);
    idle_in(); reg_addr = 2'(a); reg_rd = 1; cyc(); reg_rd = 0;
  endtask

  task automatic wr(input int a, input bit v);
    idle_in(); reg_addr = 2'(a); reg_wr = 1; reg_wdata = v; cyc(); reg_wr = 0;
  endtask

  // 6 slot groups of NCH bytes: 2 section overhead, 1 parity, 3 payload
  task automatic send_frame(input logic [7:0] inj[NCH], input int pulse_at);
    int idx = 0;
    for (int c = 0; c < NCH; c++) begin sent_par[c] = cur_par[c]; cur_par[c] = 8'h00; end
    for (int g = 0; g < 6; g++) begin
      for (int c = 0; c < NCH; c++) begin
        idle_in();
        din_vld = 1; ch_idx = 2'(c); soh = (g < 2); par_pos = (g == 2);
        frame_start = (idx == 0);
        din = (g == 2) ? (sent_par[c] ^ inj[c]) : 8'($urandom);
        if (g != 2 && $urandom_range(0, 1) == 1) par_pos = 0;
        if (g < 2) par_pos = 0;
        if (!soh) cur_par[c] ^= din;
        sec_pulse = (idx == pulse_at);
        cyc();
        idx++;
      end
      if (g == 2) idle(0);
    end
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] z[NCH], ff[NCH], t[NCH];
    for (int c = 0; c < NCH; c++) begin
      z[c] = 8'h00; ff[c] = 8'hFF; cur_par[c] = 8'h00;
      m_acc[c] = 8'h00; m_prev[c] = 8'h00; m_ok[c] = 0;
    end
    m_seen = 0; m_fen = 0; m_sts = 0; m_msk = 1;
    m_fb = 0; m_fk = 0; m_ofb = 0; m_ofk = 0; m_rb = 0; m_rk = 0; m_cb = 0; m_ck = 0;
    last_fb = -1; last_fk = -1; last_rd = -1;
    rst_n = 0; idle_in(); reg_addr = 0;
    def_sef = 0; def_los = 0; def_lof = 0; def_ais = 0;
    cfg_cnt_clr_rd = 0; cfg_sts_clr_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: reset state
    chk("R11 frm_en", int'(frm_en), 0);
    chk("R11 irq", int'(irq), 0);
    rd(0); chk("R11 bit cache", last_rd, 0);
    rd(2); chk("R11 status", last_rd, 0);
    rd(3); chk("R9 mask reset value", last_rd, 1);

    // R2: first frame has corrupted parity bytes, nothing to compare with
    send_frame(ff, -1);
    send_frame(z, -1);
    chk("R2 first frame ignored bits", last_fb, 0);
    t = '{8'h00, 8'h01, 8'h00, 8'h00};
    send_frame(t, -1);
    chk("R1 clean frame blocks", last_fk, 0);
    t = '{8'h81, 8'h00, 8'hFF, 8'h00};
    send_frame(t, -1);
    chk("R3 single bit", last_fb, 1);
    chk("R3 single block", last_fk, 1);
    send_frame(z, -1);
    chk("R3 multi bits", last_fb, 10);
    chk("R3 multi blocks", last_fk, 2);

    // R8/R9: clear by write mode
    wr(3, 0);
    chk("R9 irq unmasked", int'(irq), 1);
    rd(2); rd(2); chk("R8 read keeps status", last_rd, 1);
    wr(2, 1); rd(2); chk("R8 write clears status", last_rd, 0);

    // R5/R7: transfer and clear-on-read
    idle(1);
    rd(0); chk("R5 bit cache", last_rd, 11);
    rd(1); chk("R5 block cache", last_rd, 3);
    rd(0); chk("R7 read keeps cache", last_rd, 11);
    cfg_cnt_clr_rd = 1;
    rd(0); rd(0); chk("R7 read clears cache", last_rd, 0);
    cfg_cnt_clr_rd = 0;

    // R5: error in the transfer cycle lands in the new period
    t = '{8'h03, 8'h00, 8'h00, 8'h00};
    send_frame(t, 8);
    send_frame(z, -1);
    idle(1);
    rd(0); chk("R5 transfer-cycle bits kept", last_rd, 2);
    rd(1); chk("R5 transfer-cycle block kept", last_rd, 1);

    // R6: saturation
    for (int k = 0; k < 4; k++) send_frame(ff, -1);
    send_frame(z, -1);
    chk("R9 irq after errors", int'(irq), 1);
    idle(1);
    rd(0); chk("R6 bits saturate", last_rd, 63);
    rd(1); chk("R6 blocks saturate", last_rd, 15);
    wr(3, 1);
    chk("R9 masked irq", int'(irq), 0);

    // R10: defect suppression and recovery
    def_los = 1;
    send_frame(ff, -1);
    @(negedge clk);
    def_los = 0;
    send_frame(ff, -1);
    send_frame(z, -1);
    chk("R10 frame after defect not compared", last_fb, 0);
    t = '{8'h00, 8'h10, 8'h00, 8'h00};
    send_frame(t, -1);
    send_frame(z, -1);
    chk("R10 comparison resumes", last_fb, 1);
    def_ais = 1; idle(0); def_ais = 0;

    // R8: clear-on-read mode
    cfg_sts_clr_rd = 1;
    rd(2); chk("R8 status before read-clear", last_rd, 1);
    rd(2); chk("R8 status read-cleared", last_rd, 0);
    repeat (3) idle(0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule